// File: doc/BRIEF.md
# Delta-Readout Successive-Approximation Controller

This block sequences a 10-bit successive-approximation conversion for a column readout channel whose successive samples come from neighbouring pixels. Instead of clearing its whole code register between samples, it keeps the upper bits of the previous result. It checks that the new sample still lies inside the code window those bits define, and then resolves only the lower bits. The pixel scan turns round at each row end, so the first pixel of a new row sits next to the last pixel of the row before. The retained bits therefore carry straight over a row change and need no row-level storage.

The controller drives a binary-weighted DAC code and reads back a single comparator decision each clock. A sample can fall outside the retained window. This happens on the first conversion after reset, and also when `frame_start` is given with `start`. In those cases the controller runs a full MSB-first search. Each conversion ends with a one-cycle `done` strobe, the 10-bit result, and the number of comparisons it used.

Top module: `delta_sar_ctrl`

## Requirements
- R1: With a comparator that reports `cmp_hi`=1 when the input is at or above `dac_code`, `result` equals the sampled input code for every input from 0 to 1023.
- R2: The first conversion after reset, and any conversion started with `frame_start`=1, is a full search. Its first trial code is 512 (only bit 9 set), it resolves bits 9 down to 0 one per clock, and it reports 10 comparisons.
- R3: Any other conversion first compares against the window bottom {kept bits, five zeros}. It then compares against the window top, which is (kept bits + 1) followed by five zeros. After that it resolves bits 4 down to 0, for 7 comparisons in total.
- R4: If the window-bottom check shows the input is below the window, the upper bits are cleared and a full search follows, for 11 comparisons.
- R5: If the window-top check shows the input is at or above the top, a full search follows, for 12 comparisons.
- R6: When the kept bits are all ones, the window-top check is skipped, giving 6 comparisons for an in-window sample.
- R7: The kept bits are always bits 9..5 of the most recent result, with no row or column input involved.
- R8: `done` is high for exactly one cycle. It rises exactly N clock edges after the edge that takes `start`, where N is the reported comparison count. `busy` is high from the accept edge until `done`.
- R9: A `start` that arrives while `busy` is high is ignored, together with its `frame_start`.
- R10: After reset, `done` and `busy` are low.
- R11: A sample equal to the window bottom counts as inside the window. A sample equal to the window top counts as outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| frame_start | input | 1 | With start: force a full search |
| cmp_hi | input | 1 | Comparator decision: input at or above dac_code |
| dac_code | output | 10 | Code applied to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 10 | Converted code, held until the next done |
| steps | output | 4 | Comparisons used by the last conversion |

## Verification
The hardest case to reach is the set of window boundaries. A sample must land exactly on the bottom or the top of the window left by the previous pixel, or the retained bits must be all ones, so that the top check is skipped. The bench gets there by chaining samples: each sample is chosen to set the kept bits that the next sample needs. For example, 608 follows a sample in 576..607, and 1023 follows 1000. A start is also pulsed during a conversion to show that it is ignored.

// File: rtl/sar_delta_pkg.sv
package sar_delta_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WLO,
        ST_WHI,
        ST_BIT
    } sar_state_e;

    typedef struct packed {
        logic full;
        logic last;
    } sar_flags_t;

endpackage

// File: rtl/sar_keep_reg.sv
module sar_keep_reg #(
    parameter int KEEP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [KEEP_W-1:0] din,
    output logic [KEEP_W-1:0] keep_q,
    output logic              valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            keep_q  <= din;
            valid_q <= 1'b1;
        end
    end

    // R7
    keep_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (keep_q == $past(din)) && valid_q);
endmodule

// File: rtl/sar_window.sv
module sar_window #(
    parameter int RES_W  = 10,
    parameter int KEEP_W = 5
) (
    input  logic [KEEP_W-1:0] keep,
    output logic [RES_W-1:0]  lo_code,
    output logic [RES_W-1:0]  hi_code,
    output logic              hi_valid
);
    localparam int LOW_W = RES_W - KEEP_W;

    logic [KEEP_W-1:0] keep_inc;

    always_comb begin
        keep_inc = keep + KEEP_W'(1);
        lo_code  = {keep, {LOW_W{1'b0}}};
        hi_code  = {keep_inc, {LOW_W{1'b0}}};
        hi_valid = ~(&keep);
    end
endmodule

// File: rtl/delta_sar_ctrl.sv
module delta_sar_ctrl
    import sar_delta_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int KEEP_W = 5,
    localparam int CNT_W = $clog2(RES_W + 3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             frame_start,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic [CNT_W-1:0] steps
);
    localparam int LOW_W = RES_W - KEEP_W;
    localparam int IDX_W = $clog2(RES_W);

    sar_state_e        state_q;
    sar_flags_t        flg;
    logic [RES_W-1:0]  acc_q;
    logic [RES_W-1:0]  trial;
    logic [RES_W-1:0]  final_code;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  steps_q;
    logic [RES_W-1:0]  res_q;
    logic              done_q;
    logic              full_q;
    logic [KEEP_W-1:0] keep_q;
    logic              keep_valid;
    logic [RES_W-1:0]  lo_code;
    logic [RES_W-1:0]  hi_code;
    logic              hi_valid;

    sar_window #(.RES_W(RES_W), .KEEP_W(KEEP_W)) u_win (
        .keep     (keep_q),
        .lo_code  (lo_code),
        .hi_code  (hi_code),
        .hi_valid (hi_valid)
    );

    always_comb begin
        trial      = acc_q | ({{(RES_W-1){1'b0}}, 1'b1} << idx_q);
        final_code = cmp_hi ? trial : acc_q;
        flg.full   = full_q;
        flg.last   = (state_q == ST_BIT) && (idx_q == '0);
    end

    sar_keep_reg #(.KEEP_W(KEEP_W)) u_keep (
        .clk     (clk),
        .rst     (rst),
        .load    (flg.last),
        .din     (final_code[RES_W-1:LOW_W]),
        .keep_q  (keep_q),
        .valid_q (keep_valid)
    );

    always_comb begin
        case (state_q)
            ST_WLO:  dac_code = lo_code;
            ST_WHI:  dac_code = hi_code;
            ST_BIT:  dac_code = trial;
            default: dac_code = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            idx_q   <= '0;
            steps_q <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        steps_q <= '0;
                        if (frame_start || !keep_valid) begin
                            state_q <= ST_BIT;
                            full_q  <= 1'b1;
                            acc_q   <= '0;
                            idx_q   <= IDX_W'(RES_W - 1);
                        end else begin
                            state_q <= ST_WLO;
                            full_q  <= 1'b0;
                        end
                    end
                end
                ST_WLO: begin
                    steps_q <= steps_q + CNT_W'(1);
                    if (!cmp_hi) begin
                        state_q <= ST_BIT;
                        full_q  <= 1'b1;
                        acc_q   <= '0;
                        idx_q   <= IDX_W'(RES_W - 1);
                    end else if (hi_valid) begin
                        state_q <= ST_WHI;
                    end else begin
                        state_q <= ST_BIT;
                        acc_q   <= lo_code;
                        idx_q   <= IDX_W'(LOW_W - 1);
                    end
                end
                ST_WHI: begin
                    steps_q <= steps_q + CNT_W'(1);
                    state_q <= ST_BIT;
                    if (cmp_hi) begin
                        full_q <= 1'b1;
                        acc_q  <= '0;
                        idx_q  <= IDX_W'(RES_W - 1);
                    end else begin
                        acc_q <= lo_code;
                        idx_q <= IDX_W'(LOW_W - 1);
                    end
                end
                default: begin
                    steps_q <= steps_q + CNT_W'(1);
                    acc_q   <= final_code;
                    if (flg.last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        res_q   <= final_code;
                    end else begin
                        idx_q <= idx_q - IDX_W'(1);
                    end
                end
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;
    assign steps  = steps_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    frame_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && frame_start) |=> (dac_code == {1'b1, {(RES_W-1){1'b0}}}));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R3
    delta_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BIT && !flg.full) |-> (dac_code[RES_W-1:LOW_W] == keep_q));

    // R6
    steps_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (steps >= CNT_W'(LOW_W + 1)) && (steps <= CNT_W'(RES_W + 2)));
endmodule

// File: tb/sim_delta_sar_ctrl.sv
module sim_delta_sar_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       frame_start = 1'b0;
    logic       cmp_hi;
    logic [9:0] dac_code;
    logic       busy;
    logic       done;
    logic [9:0] result;
    logic [3:0] steps;
    logic [9:0] vin = '0;
    logic [4:0] exp_keep = '0;
    logic       have_keep = 1'b0;
    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 0;

    always #(CLK_P/2) clk = ~clk;
    assign cmp_hi = (vin >= dac_code);

    delta_sar_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .frame_start(frame_start),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .busy(busy), .done(done),
        .result(result), .steps(steps)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic [9:0] v, input logic fs, input int exp_steps,
                            input bit poke_busy, input string tag);
        int lat;
        int first;
        @(negedge clk);
        vin = v; start = 1'b1; frame_start = fs;
        @(negedge clk);
        start = 1'b0; frame_start = 1'b0;
        first = (fs || !have_keep || exp_steps == 10) ? 512 : int'(exp_keep) * 32;
        if (exp_steps == 10) check({tag, " R2 first trial"}, dac_code, first);
        else if (exp_steps == 7 || exp_steps == 6) check({tag, " R3 window bottom"}, dac_code, first);
        check({tag, " R8 busy"}, busy, 1);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke_busy && lat == 3) begin
                start = 1'b1; frame_start = 1'b1;
            end else begin
                start = 1'b0; frame_start = 1'b0;
            end
        end
        start = 1'b0; frame_start = 1'b0;
        check({tag, " R1 result"}, result, v);
        check({tag, " steps"}, steps, exp_steps);
        check({tag, " R8 latency"}, lat, exp_steps + 1);
        @(negedge clk);
        check({tag, " R8 done width"}, done, 0);
        if (poke_busy) check({tag, " R9 no restart"}, busy, 0);
        exp_keep  = v[9:5];
        have_keep = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 done", done, 0);
        check("R10 busy", busy, 0);
    endtask

    task automatic t_full_first();  run_conv(10'd600, 1'b0, 10, 0, "R10 R2 first after reset"); endtask
    task automatic t_delta();       run_conv(10'd590, 1'b0, 7, 0, "R3 in window");             endtask
    task automatic t_bottom_edge(); run_conv(10'd576, 1'b0, 7, 0, "R11 bottom edge");          endtask
    task automatic t_top_edge();    run_conv(10'd608, 1'b0, 12, 0, "R11 R5 top edge");         endtask
    task automatic t_below();       run_conv(10'd600, 1'b0, 11, 0, "R4 below");                endtask
    task automatic t_frame();       run_conv(10'd605, 1'b1, 10, 0, "R2 frame start");          endtask
    task automatic t_above();       run_conv(10'd1000, 1'b0, 12, 0, "R5 above");               endtask
    task automatic t_all_ones();
        run_conv(10'd1023, 1'b0, 6, 0, "R6 kept all ones");
        run_conv(10'd992, 1'b0, 6, 0, "R6 R7 kept all ones low");
    endtask
    task automatic t_zero();
        run_conv(10'd0, 1'b0, 11, 0, "R4 to zero");
        run_conv(10'd5, 1'b0, 7, 0, "R7 kept zero");
    endtask
    task automatic t_busy_start();  run_conv(10'd20, 1'b0, 7, 1, "R9 start while busy");      endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_first();
        t_delta();
        t_bottom_edge();
        t_top_edge();
        t_below();
        t_frame();
        t_above();
        t_all_ones();
        t_zero();
        t_busy_start();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule